// File: doc/BRIEF.md
# Rising-Edge Manchester Message Decoder

This block recovers a message, as a stream of bits, from a single Manchester-coded wire. It looks only at the rising transitions of the line. Each time a rising edge arrives, a tick counter gives the time since the previous rising edge, in clock cycles. That distance is compared against windows whose boundaries are multiples of a quarter bit slot. Which windows apply depends on the last bit that was decoded. The result is one bit or a pair of bits. Each bit is presented for one cycle on a valid strobe. Falling transitions carry no information here and are never looked at.

A message always opens with a rising edge that stands for a 1. It closes when the line stays quiet past the longest legal gap. The block then appends one 0 in two cases: when the message ended in 0, or when it ended in 1 with an even number of bits. A one-cycle completion pulse follows, and the decoder waits for the next opening edge. A rising edge that comes too soon after the previous one raises a one-cycle error pulse and abandons the message. The line input is asynchronous and passes through a two-flop synchronizer first.

Top module: `mrx_rise_decoder`

## Requirements
- R1: The first rising edge seen while waiting decodes as a single 1 and restarts the bit-count parity, whatever the state of any earlier message.
- R2: Within a message, a rising edge whose distance from the previous one is below L3 pulses `rx_err` for one cycle. No bit and no completion pulse follow, and the block waits for a new first edge.
- R3: After a decoded 1, a distance in [L3, L5) yields the bit 1 and a distance in [L5, L7) yields the bit 0.
- R4: After a decoded 1, a distance in [L7, L9) yields 0 and then 1, on two consecutive clock cycles.
- R5: After a decoded 0, a distance in [L3, L5) yields 0 and a distance in [L5, L7) yields 0 and then 1, on two consecutive cycles.
- R6: The message ends when the elapsed count reaches L9 after a 1, or L7 after a 0, with no earlier edge. A rising edge that lands exactly on that count is dropped.
- R7: When a message ends on a 0, one extra 0 is emitted before completion.
- R8: When a message ends on a 1, one extra 0 is emitted only if the number of bits emitted so far is even. If it is odd, nothing is added.
- R9: After the last bit (padding included), `msg_done` is high for exactly one cycle. The next rising edge then starts a new message.
- R10: Falling edges and the width of the high phase of the line have no effect on the output. Only the spacing between rising edges matters.
- R11: Lk = k*QUARTER + floor(k*QUARTER*TOL_NUM/TOL_DEN). This is the upper edge of the tolerance band around k quarters. A distance equal to Lk falls in the window above the boundary. With defaults (20, 1/20), L3=63, L5=105, L7=147 and L9=189.
- R12: While reset is held and right after it, `bit_valid`, `msg_done` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous Manchester line |
| bit_valid | output | 1 | A decoded bit is present this cycle |
| bit_value | output | 1 | Value of the decoded bit |
| msg_done | output | 1 | One-cycle pulse at message completion |
| rx_err | output | 1 | One-cycle pulse: rising edge came too early |

## Verification
The bench uses the default quarter of 20 cycles and a 1/20 tolerance, so every window limit is a whole number of cycles (63, 105, 147, 189). Each limit can therefore be hit exactly and one cycle below. Short quarters keep random messages of up to eight tokens cheap, so many of them fit in the run. The random messages mix every pair of decoded bits, every padding case and a range of high-phase widths.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ERR,
        CL_ONE,
        CL_ZERO,
        CL_ZERO_ONE,
        CL_END
    } win_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_SECOND,
        ST_PAD,
        ST_DONE
    } dec_state_e;

    typedef struct packed {
        logic valid;
        logic value;
    } bit_out_t;

    // Upper edge of the tolerance band around k quarters.
    function automatic int edge_limit(int k, int quarter, int tol_num, int tol_den);
        return k * quarter + (k * quarter * tol_num) / tol_den;
    endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], line_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    // R10: a rising-edge pulse never lasts two cycles
    p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/mdec_timer.sv
module mdec_timer #(
    parameter int W   = 8,
    parameter int SAT = 189
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] elapsed
);
    localparam logic [W-1:0] SAT_V = W'(SAT);

    always_ff @(posedge clk) begin
        if (rst)                    elapsed <= '0;
        else if (restart)           elapsed <= W'(1);
        else if (elapsed != SAT_V)  elapsed <= elapsed + W'(1);
    end

    // R11: distance counting starts at one cycle after an edge
    p_timer_restart_r11: assert property (@(posedge clk) disable iff (rst)
        restart |=> elapsed == W'(1));

    p_timer_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        elapsed <= SAT_V);

endmodule

// File: rtl/mdec_window.sv
module mdec_window
    import mdec_pkg::*;
#(
    parameter int QUARTER = 20,
    parameter int TOL_NUM = 1,
    parameter int TOL_DEN = 20,
    parameter int W       = 8
) (
    input  logic [W-1:0] elapsed,
    input  logic         last_bit,
    input  logic         rise,
    output win_class_e   cls
);
    localparam logic [W-1:0] LIM3 = W'(edge_limit(3, QUARTER, TOL_NUM, TOL_DEN));
    localparam logic [W-1:0] LIM5 = W'(edge_limit(5, QUARTER, TOL_NUM, TOL_DEN));
    localparam logic [W-1:0] LIM7 = W'(edge_limit(7, QUARTER, TOL_NUM, TOL_DEN));
    localparam logic [W-1:0] LIM9 = W'(edge_limit(9, QUARTER, TOL_NUM, TOL_DEN));

    logic [W-1:0] lim_end;

    always_comb begin
        lim_end = last_bit ? LIM9 : LIM7;
        cls     = CL_NONE;
        if (elapsed >= lim_end) begin
            cls = CL_END;
        end else if (rise) begin
            if (elapsed < LIM3)      cls = CL_ERR;
            else if (elapsed < LIM5) cls = last_bit ? CL_ONE  : CL_ZERO;
            else if (elapsed < LIM7) cls = last_bit ? CL_ZERO : CL_ZERO_ONE;
            else                     cls = CL_ZERO_ONE;
        end
    end

endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm
    import mdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  win_class_e cls,
    output logic       last_bit,
    output logic       bit_valid,
    output logic       bit_value,
    output logic       msg_done,
    output logic       rx_err
);
    dec_state_e state;
    logic       odd;
    bit_out_t   emit;

    assign bit_valid = emit.valid;
    assign bit_value = emit.value;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            odd      <= 1'b0;
            last_bit <= 1'b1;
            emit     <= '0;
            msg_done <= 1'b0;
            rx_err   <= 1'b0;
        end else begin
            emit     <= '0;
            msg_done <= 1'b0;
            rx_err   <= 1'b0;
            case (state)
                ST_IDLE: if (rise) begin
                    emit     <= '{valid: 1'b1, value: 1'b1};
                    last_bit <= 1'b1;
                    odd      <= 1'b1;
                    state    <= ST_RUN;
                end
                ST_RUN: case (cls)
                    CL_ERR: begin
                        rx_err   <= 1'b1;
                        last_bit <= 1'b1;
                        state    <= ST_IDLE;
                    end
                    CL_ONE: begin
                        emit     <= '{valid: 1'b1, value: 1'b1};
                        last_bit <= 1'b1;
                        odd      <= ~odd;
                    end
                    CL_ZERO: begin
                        emit     <= '{valid: 1'b1, value: 1'b0};
                        last_bit <= 1'b0;
                        odd      <= ~odd;
                    end
                    CL_ZERO_ONE: begin
                        emit  <= '{valid: 1'b1, value: 1'b0};
                        odd   <= ~odd;
                        state <= ST_SECOND;
                    end
                    CL_END: state <= (!last_bit || !odd) ? ST_PAD : ST_DONE;
                    default: ;
                endcase
                ST_SECOND: begin
                    emit     <= '{valid: 1'b1, value: 1'b1};
                    last_bit <= 1'b1;
                    odd      <= ~odd;
                    state    <= ST_RUN;
                end
                ST_PAD: begin
                    emit     <= '{valid: 1'b1, value: 1'b0};
                    last_bit <= 1'b0;
                    odd      <= ~odd;
                    state    <= ST_DONE;
                end
                ST_DONE: begin
                    msg_done <= 1'b1;
                    last_bit <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: an opening edge produces a single 1
    p_first_is_one_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && rise) |=> (bit_valid && bit_value));

    // R4 / R5: a pair comes out as 0 then 1 on adjacent cycles
    p_pair_adjacent_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cls == CL_ZERO_ONE) |=> (bit_valid && !bit_value) ##1 (bit_valid && bit_value));

    // R2: an error pulse comes with no bit and no completion
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (!bit_valid && !msg_done));

    // R9: completion is a one-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        msg_done |=> !msg_done);

    // R7 / R8: the padding bit is always a 0
    p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD) |=> (bit_valid && !bit_value));

endmodule

// File: rtl/mrx_rise_decoder.sv
module mrx_rise_decoder
    import mdec_pkg::*;
#(
    parameter int QUARTER     = 20,
    parameter int TOL_NUM     = 1,
    parameter int TOL_DEN     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_value,
    output logic msg_done,
    output logic rx_err
);
    localparam int SAT = edge_limit(9, QUARTER, TOL_NUM, TOL_DEN);
    localparam int CW  = $clog2(SAT + 1);

    logic          rise;
    logic          last_bit;
    logic [CW-1:0] elapsed;
    win_class_e    cls;

    mdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .rise    (rise)
    );

    mdec_timer #(.W(CW), .SAT(SAT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (rise),
        .elapsed (elapsed)
    );

    mdec_window #(
        .QUARTER (QUARTER),
        .TOL_NUM (TOL_NUM),
        .TOL_DEN (TOL_DEN),
        .W       (CW)
    ) u_window (
        .elapsed  (elapsed),
        .last_bit (last_bit),
        .rise     (rise),
        .cls      (cls)
    );

    mdec_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .cls       (cls),
        .last_bit  (last_bit),
        .bit_valid (bit_valid),
        .bit_value (bit_value),
        .msg_done  (msg_done),
        .rx_err    (rx_err)
    );

endmodule

// File: tb/sim_mrx_rise_decoder.sv
module sim_mrx_rise_decoder;
    localparam int Q  = 20;
    localparam int L3 = 3*Q + (3*Q)/20;
    localparam int L5 = 5*Q + (5*Q)/20;
    localparam int L7 = 7*Q + (7*Q)/20;
    localparam int L9 = 9*Q + (9*Q)/20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic bit_valid, bit_value, msg_done, rx_err;

    always #5 clk = ~clk;

    mrx_rise_decoder #(.QUARTER(Q)) u0 (
        .clk(clk), .rst(rst), .line_in(line_in),
        .bit_valid(bit_valid), .bit_value(bit_value),
        .msg_done(msg_done), .rx_err(rx_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int got_bits[$];
    int got_cyc[$];
    int done_n = 0;
    int err_n = 0;
    int gaps[$];
    int widths[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (!rst) begin
        if (bit_valid) begin
            got_bits.push_back(int'(bit_value));
            got_cyc.push_back(cyc);
        end
        if (msg_done) done_n++;
        if (rx_err) err_n++;
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // classes: 0 err, 1 one, 2 zero, 3 zero-one, 4 end
    function automatic int classify(int last, int gap);
        int lend = last ? L9 : L7;
        if (gap >= lend) return 4;
        if (gap < L3) return 0;
        if (gap < L5) return last ? 1 : 2;
        if (gap < L7) return last ? 2 : 3;
        return 3;
    endfunction

    task automatic run_msg(string req);
        int eb[$];
        int pair_idx[$];
        int last = 1;
        int exp_err = 0;
        int stop = 0;
        int exp_done;
        eb.push_back(1);
        foreach (gaps[i]) begin
            if (!stop) begin
                int c = classify(last, gaps[i]);
                case (c)
                    0: begin exp_err = 1; stop = 1; end
                    1: begin eb.push_back(1); last = 1; end
                    2: begin eb.push_back(0); last = 0; end
                    3: begin eb.push_back(0); eb.push_back(1);
                             pair_idx.push_back(eb.size() - 1); last = 1; end
                    default: stop = 1;
                endcase
            end
        end
        if (!exp_err && (last == 0 || (eb.size() % 2) == 0)) eb.push_back(0);
        exp_done = exp_err ? 0 : 1;
        widths.delete();
        for (int i = 0; i <= gaps.size(); i++) widths.push_back(1 + int'($urandom_range(29)));
        @(negedge clk);
        got_bits.delete(); got_cyc.delete(); done_n = 0; err_n = 0;
        for (int i = 0; i <= gaps.size(); i++) begin
            line_in = 1'b1;
            repeat (widths[i]) @(negedge clk);
            line_in = 1'b0;
            if (i < gaps.size()) repeat (gaps[i] - widths[i]) @(negedge clk);
        end
        repeat (300) @(negedge clk);
        check(req, "bit count", got_bits.size(), eb.size());
        for (int i = 0; i < eb.size() && i < got_bits.size(); i++)
            check(req, $sformatf("bit %0d", i), got_bits[i], eb[i]);
        foreach (pair_idx[k])
            if (pair_idx[k] < got_cyc.size())
                check(req, "pair spacing (R4/R5)", got_cyc[pair_idx[k]] - got_cyc[pair_idx[k]-1], 1);
        check(req, "done pulses (R9)", done_n, exp_done);
        check(req, "error pulses (R2)", err_n, exp_err);
    endtask

    task automatic dir(string req, int g0 = -1, int g1 = -1);
        gaps.delete();
        if (g0 >= 0) gaps.push_back(g0);
        if (g1 >= 0) gaps.push_back(g1);
        run_msg(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R12", "bit_valid in reset", int'(bit_valid), 0);
        check("R12", "msg_done in reset", int'(msg_done), 0);
        check("R12", "rx_err in reset", int'(rx_err), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check("R12", "bit_valid after reset", int'(bit_valid), 0);

        // directed corner cases
        dir("R1_R8 single edge");
        dir("R3_R8 one then one", 80);
        dir("R3_R7 one then zero", 120);
        dir("R4 zero-one after one", 160);
        dir("R2 early edge", L3 - 1);
        dir("R11 at L3", L3);
        dir("R11 below L5", L5 - 1);
        dir("R11 at L5", L5);
        dir("R11 below L7", L7 - 1);
        dir("R11 at L7", L7);
        dir("R11 below L9", L9 - 1);
        dir("R6 edge at L9 dropped", L9);
        dir("R2 early after zero", 120, L3 - 1);
        dir("R5 zero after zero", 120, L3);
        dir("R5 zero below L5", 120, L5 - 1);
        dir("R5 zero-one at L5", 120, L5);
        dir("R5 zero-one below L7", 120, L7 - 1);
        dir("R6 edge at L7 dropped", 120, L7);
        dir("R9 message restarts", 80, 80);

        // random messages with varied high widths (R10)
        for (int m = 0; m < 40; m++) begin
            int last = 1;
            int n = 1 + int'($urandom_range(7));
            gaps.delete();
            for (int t = 0; t < n; t++) begin
                int jit = int'($urandom_range(8)) - 4;
                int r = last ? int'($urandom_range(2)) : int'($urandom_range(1));
                if (last) begin
                    gaps.push_back((r == 0 ? 80 : (r == 1 ? 120 : 160)) + jit);
                    last = (r == 1) ? 0 : 1;
                end else begin
                    gaps.push_back((r == 0 ? 80 : 120) + jit);
                    last = r;
                end
            end
            run_msg("R10 random message");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule